// File: doc/BRIEF.md
# Register Type-Tag Tracker and Unit Dispatcher

This block keeps one type bit for every architectural register, apart from the register data. A bit of 1 means the register holds a floating-point value. A bit of 0 means integer, address or other non-float data. The tag lets one shared opcode serve both number kinds. In the decode cycle, the block reads the tags of the two source registers, chooses the integer or the floating-point function unit, and gives the tag that the destination will receive. Source tags that do not match, or tags that a type-restricted operation does not accept, raise an exception strobe instead of a unit choice.

Tags change through a single writeback port. This port carries arithmetic results, integer loads, and float loads of either width. A masked restore port loads tags back at the exit of a call or interrupt. A masked save port captures the tags of the saved registers so they can be stored with the register contents. Any write that happens in the same cycle as a decode read is forwarded to that read. The same applies to a save capture.

Top module: `regtag_dispatch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every tag bit is 0 and the save image is 0.
- R2: On a clock edge, writeback kind 3 (float single load) or 4 (float double load) sets the tag of `wb_rd`. Kind 2 (integer load) clears it. Kind 1 (result) writes `wb_tag`. Kind 0 changes no tag.
- R3: Class 1 (shared arithmetic) with equal source tags selects unit 2 (float) when the tags are 1 and unit 1 (integer) when they are 0. The result tag equals the source tag and there is no exception.
- R4: Class 1 with differing source tags raises `tag_exc`, with unit 0 (none) and result tag 0.
- R5: Class 2 (unary tag-chosen pair, for example transcendental versus population count) looks only at the tag of `dec_rs1`. Tag 1 gives float unit and result tag 1. Tag 0 gives integer unit and result tag 0. It never raises an exception.
- R6: Class 3 (float-only) needs both source tags to be 1 and gives float unit with result tag 1. Class 4 (integer-only, for example shifts) needs both tags to be 0 and gives integer unit with result tag 0. Any other tag pair raises `tag_exc` with unit 0.
- R7: Class 5 (OR) with `dec_rs2` = 0 gives integer unit and result tag 0. Otherwise, with `dec_rs1` = `dec_rs2`, it gives integer unit and result tag 1. Otherwise it follows the class 4 rules.
- R8: A writeback or restore to a source register in the same cycle as the decode is seen by that decode.
- R9: At a clock edge with `save_en`, `save_img` captures the post-edge tags masked by `save_mask`, with unmasked bits 0. It holds that value until the next save.
- R10: At a clock edge with `rest_en`, each tag bit set in `rest_mask` takes the matching `rest_tags` bit. This wins over a writeback to the same register. Unmasked tags keep their other updates.
- R11: With `dec_valid` low, or with classes 0, 6 and 7, the outputs are unit 0, result tag 0 and no exception. Decoding alone never changes a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is in decode |
| dec_cls | input | 3 | Operation class (0 none, 1 arithmetic, 2 pair, 3 float-only, 4 integer-only, 5 OR) |
| dec_rs1 | input | 5 | First source register index |
| dec_rs2 | input | 5 | Second source register index |
| wb_kind | input | 3 | Writeback kind (0 none, 1 result, 2 integer load, 3 float single, 4 float double) |
| wb_rd | input | 5 | Writeback destination index |
| wb_tag | input | 1 | Tag carried by a result writeback |
| rest_en | input | 1 | Restore tags this cycle |
| rest_mask | input | 32 | Registers being restored |
| rest_tags | input | 32 | Tag values being restored |
| save_en | input | 1 | Capture tags this cycle |
| save_mask | input | 32 | Registers being saved |
| unit_sel | output | 2 | Selected unit (0 none, 1 integer, 2 float) |
| res_tag | output | 1 | Tag for the destination |
| tag_exc | output | 1 | Type mismatch or disallowed tag |
| tag_vec | output | 32 | Current tag of every register |
| save_img | output | 32 | Tags captured by the last save |

## Verification
Two events can meet a decode read in the same cycle. One is a writeback, or a restore, whose target is a source register of the decoded instruction. The other is a writeback to the same register that a restore also covers. The bench provokes both. It decodes an arithmetic operation while a float load targets one of its sources, and it drives a restore together with a conflicting load on a masked register and a save capture. The bench judges the unit choice against the tag after the write. It judges the stored tag and the save image against a model in which the restore is applied last.

// File: rtl/regtag_pkg.sv
package regtag_pkg;

  localparam logic [2:0] CLS_NONE  = 3'd0;
  localparam logic [2:0] CLS_ARITH = 3'd1;
  localparam logic [2:0] CLS_PAIR  = 3'd2;
  localparam logic [2:0] CLS_FONLY = 3'd3;
  localparam logic [2:0] CLS_IONLY = 3'd4;
  localparam logic [2:0] CLS_OR    = 3'd5;

  localparam logic [2:0] WB_NONE = 3'd0;
  localparam logic [2:0] WB_RES  = 3'd1;
  localparam logic [2:0] WB_LDI  = 3'd2;
  localparam logic [2:0] WB_LDFS = 3'd3;
  localparam logic [2:0] WB_LDFD = 3'd4;

  typedef enum logic [1:0] {
    UNIT_NONE = 2'd0,
    UNIT_INT  = 2'd1,
    UNIT_FP   = 2'd2
  } unit_e;

  typedef struct packed {
    unit_e unit;
    logic  res_tag;
    logic  exc;
  } verdict_t;

  // {write happens, tag written} for a writeback kind
  function automatic logic [1:0] fn_wb_effect(logic [2:0] kind, logic tag);
    case (kind)
      WB_RES:           return {1'b1, tag};
      WB_LDI:           return 2'b10;
      WB_LDFS, WB_LDFD: return 2'b11;
      default:          return 2'b00;
    endcase
  endfunction

  function automatic verdict_t fn_pure(logic want_fp, logic t1, logic t2);
    verdict_t v;
    if (t1 == want_fp && t2 == want_fp) begin
      v.unit    = want_fp ? UNIT_FP : UNIT_INT;
      v.res_tag = want_fp;
      v.exc     = 1'b0;
    end else begin
      v = '{UNIT_NONE, 1'b0, 1'b1};
    end
    return v;
  endfunction

  function automatic verdict_t fn_verdict(logic [2:0] cls, logic t1, logic t2,
                                          logic same_src, logic src2_zero);
    verdict_t v;
    v = '{UNIT_NONE, 1'b0, 1'b0};
    case (cls)
      CLS_ARITH: begin
        if (t1 != t2) v.exc = 1'b1;
        else v = fn_pure(t1, t1, t2);
      end
      CLS_PAIR:  v = '{(t1 ? UNIT_FP : UNIT_INT), t1, 1'b0};
      CLS_FONLY: v = fn_pure(1'b1, t1, t2);
      CLS_IONLY: v = fn_pure(1'b0, t1, t2);
      CLS_OR: begin
        if (src2_zero)     v = '{UNIT_INT, 1'b0, 1'b0};
        else if (same_src) v = '{UNIT_INT, 1'b1, 1'b0};
        else               v = fn_pure(1'b0, t1, t2);
      end
      default: v = '{UNIT_NONE, 1'b0, 1'b0};
    endcase
    return v;
  endfunction

endpackage

// File: rtl/regtag_store.sv
module regtag_store
  import regtag_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      wb_kind,
  input  logic [IDXW-1:0] wb_rd,
  input  logic            wb_tag,
  input  logic            rest_en,
  input  logic [NREG-1:0] rest_mask,
  input  logic [NREG-1:0] rest_tags,
  output logic [NREG-1:0] tag_q,
  output logic [NREG-1:0] tag_eff
);

  logic [1:0]      wb_fx;
  logic [NREG-1:0] after_wb;
  logic            ld_set_ev;
  logic            ld_clr_ev;

  assign wb_fx = fn_wb_effect(wb_kind, wb_tag);

  always_comb begin
    after_wb = tag_q;
    if (wb_fx[1]) after_wb[wb_rd] = wb_fx[0];
    tag_eff = after_wb;
    if (rest_en) tag_eff = (after_wb & ~rest_mask) | (rest_tags & rest_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_eff;
  end

  assign ld_set_ev = (wb_kind == WB_LDFS || wb_kind == WB_LDFD) &&
                     !(rest_en && rest_mask[wb_rd]);
  assign ld_clr_ev = (wb_kind == WB_LDI) && !(rest_en && rest_mask[wb_rd]);

  // R1
  tags_clear_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> tag_q == '0);

  // R2
  float_load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_set_ev |=> tag_q[$past(wb_rd)]);

  // R2
  int_load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_clr_ev |=> !tag_q[$past(wb_rd)]);

  // R10
  restore_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rest_en |=> ((tag_q ^ $past(rest_tags)) & $past(rest_mask)) == '0);

  // R11
  idle_keeps_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_kind == WB_NONE && !rest_en) |=> tag_q == $past(tag_q));

endmodule

// File: rtl/regtag_classify.sv
module regtag_classify
  import regtag_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            dec_valid,
  input  logic [2:0]      dec_cls,
  input  logic [IDXW-1:0] dec_rs1,
  input  logic [IDXW-1:0] dec_rs2,
  input  logic [NREG-1:0] tag_eff,
  output verdict_t        verdict
);

  logic src1_tag;
  logic src2_tag;
  logic same_src;
  logic src2_zero;

  assign src1_tag  = tag_eff[dec_rs1];
  assign src2_tag  = tag_eff[dec_rs2];
  assign same_src  = (dec_rs1 == dec_rs2);
  assign src2_zero = (dec_rs2 == '0);

  always_comb begin
    if (dec_valid) verdict = fn_verdict(dec_cls, src1_tag, src2_tag, same_src, src2_zero);
    else           verdict = '{UNIT_NONE, 1'b0, 1'b0};
  end

endmodule

// File: rtl/regtag_save.sv
module regtag_save #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_en,
  input  logic [NREG-1:0] save_mask,
  input  logic [NREG-1:0] tag_eff,
  output logic [NREG-1:0] save_img
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       save_img <= '0;
    else if (save_en) save_img <= tag_eff & save_mask;
  end

  // R9
  save_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !save_en |=> save_img == $past(save_img));

endmodule

// File: rtl/regtag_dispatch.sv
module regtag_dispatch
  import regtag_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic [2:0]      dec_cls,
  input  logic [IDXW-1:0] dec_rs1,
  input  logic [IDXW-1:0] dec_rs2,
  input  logic [2:0]      wb_kind,
  input  logic [IDXW-1:0] wb_rd,
  input  logic            wb_tag,
  input  logic            rest_en,
  input  logic [NREG-1:0] rest_mask,
  input  logic [NREG-1:0] rest_tags,
  input  logic            save_en,
  input  logic [NREG-1:0] save_mask,
  output logic [1:0]      unit_sel,
  output logic            res_tag,
  output logic            tag_exc,
  output logic [NREG-1:0] tag_vec,
  output logic [NREG-1:0] save_img
);

  logic [NREG-1:0] tag_q;
  logic [NREG-1:0] tag_eff;
  verdict_t        verdict;

  regtag_store #(.NREG(NREG)) store_i (
    .clk(clk), .rst_n(rst_n), .wb_kind(wb_kind), .wb_rd(wb_rd), .wb_tag(wb_tag),
    .rest_en(rest_en), .rest_mask(rest_mask), .rest_tags(rest_tags),
    .tag_q(tag_q), .tag_eff(tag_eff)
  );

  regtag_classify #(.NREG(NREG)) classify_i (
    .dec_valid(dec_valid), .dec_cls(dec_cls), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
    .tag_eff(tag_eff), .verdict(verdict)
  );

  regtag_save #(.NREG(NREG)) save_i (
    .clk(clk), .rst_n(rst_n), .save_en(save_en), .save_mask(save_mask),
    .tag_eff(tag_eff), .save_img(save_img)
  );

  assign unit_sel = verdict.unit;
  assign res_tag  = verdict.res_tag;
  assign tag_exc  = verdict.exc;
  assign tag_vec  = tag_q;

  // R4
  exc_blocks_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_exc |-> (unit_sel == UNIT_NONE && !res_tag));

  // R11
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (unit_sel == UNIT_NONE && !res_tag && !tag_exc));

  // R5
  pair_never_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_cls == CLS_PAIR) |-> (!tag_exc && unit_sel != UNIT_NONE));

  // R3
  fp_unit_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_cls == CLS_ARITH && unit_sel == UNIT_FP) |-> res_tag);

  // R9
  save_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |=> save_img == (tag_q & $past(save_mask)));

endmodule

// File: tb/regtag_dispatch_tb_top.sv
module regtag_dispatch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [2:0]  dec_cls = '0;
  logic [4:0]  dec_rs1 = '0, dec_rs2 = '0;
  logic [2:0]  wb_kind = '0;
  logic [4:0]  wb_rd = '0;
  logic        wb_tag = 1'b0;
  logic        rest_en = 1'b0;
  logic [N-1:0] rest_mask = '0, rest_tags = '0;
  logic        save_en = 1'b0;
  logic [N-1:0] save_mask = '0;
  logic [1:0]  unit_sel;
  logic        res_tag, tag_exc;
  logic [N-1:0] tag_vec, save_img;

  int errors = 0;
  int checks = 0;
  logic [N-1:0] mdl = '0;
  logic [N-1:0] img = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regtag_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_cls(dec_cls),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .wb_kind(wb_kind), .wb_rd(wb_rd),
    .wb_tag(wb_tag), .rest_en(rest_en), .rest_mask(rest_mask), .rest_tags(rest_tags),
    .save_en(save_en), .save_mask(save_mask), .unit_sel(unit_sel), .res_tag(res_tag),
    .tag_exc(tag_exc), .tag_vec(tag_vec), .save_img(save_img)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {unit, res_tag, exc}; unit 0 none, 1 int, 2 fp
  function automatic logic [3:0] expect_dec(int c, bit a, bit b, bit same, bit zero);
    bit both_f = a && b;
    bit both_i = !a && !b;
    if (c == 1) return (a != b) ? 4'b0001 : (a ? 4'b1010 : 4'b0100);
    if (c == 2) return a ? 4'b1010 : 4'b0100;
    if (c == 3) return both_f ? 4'b1010 : 4'b0001;
    if (c == 4) return both_i ? 4'b0100 : 4'b0001;
    if (c == 5) begin
      if (zero) return 4'b0100;
      if (same) return 4'b0110;
      return both_i ? 4'b0100 : 4'b0001;
    end
    return 4'b0000;
  endfunction

  function automatic logic [N-1:0] wb_apply(logic [N-1:0] t, int kind, int rd, bit tg);
    logic [N-1:0] r = t;
    if (kind == 1) r[rd] = tg;
    else if (kind == 2) r[rd] = 1'b0;
    else if (kind == 3 || kind == 4) r[rd] = 1'b1;
    return r;
  endfunction

  task automatic idle_inputs();
    dec_valid = 1'b0; dec_cls = '0; wb_kind = '0; rest_en = 1'b0; save_en = 1'b0;
  endtask

  // one writeback cycle, model follows
  task automatic do_wb(int kind, int rd, bit tg);
    @(negedge clk);
    idle_inputs();
    wb_kind = kind[2:0]; wb_rd = rd[4:0]; wb_tag = tg;
    @(posedge clk);
    mdl = wb_apply(mdl, kind, rd, tg);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tags in reset", tag_vec, '0);
    chk("R1 image in reset", save_img, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tags after reset", tag_vec, '0);
    chk("R11 idle outputs", {unit_sel, res_tag, tag_exc}, 4'b0000);

    // R2: every load / result kind over every register
    for (int r = 0; r < N; r++) begin
      if (r % 3 == 0)      do_wb((r % 2) ? 4 : 3, r, 1'b0);
      else if (r % 3 == 1) do_wb(2, r, 1'b1);
      else                 do_wb(1, r, r[2]);
    end
    chk("R2 tags after load sweep", tag_vec, mdl);
    do_wb(2, 3, 1'b1);
    chk("R2 int load clears float reg", tag_vec[3], 1'b0);
    do_wb(4, 3, 1'b0);
    chk("R2 double float load sets", tag_vec[3], 1'b1);
    do_wb(0, 4, 1'b1);
    chk("R2 kind none leaves tags", tag_vec, mdl);
    do_wb(5, 4, 1'b1);
    chk("R2 unused kind leaves tags", tag_vec, mdl);

    // R3 R4 R5 R6 R7 R11: exhaustive decode sweep
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          @(negedge clk);
          dec_valid = 1'b1; dec_cls = c[2:0]; dec_rs1 = a[4:0]; dec_rs2 = b[4:0];
          #1;
          chk($sformatf("R3/R4/R5/R6/R7 cls=%0d rs1=%0d rs2=%0d", c, a, b),
              {unit_sel, res_tag, tag_exc},
              expect_dec(c, mdl[a], mdl[b], a == b, b == 0));
        end
      end
    end
    @(negedge clk);
    dec_valid = 1'b0; dec_cls = 3'd1;
    #1;
    chk("R11 outputs with dec_valid low", {unit_sel, res_tag, tag_exc}, 4'b0000);
    chk("R11 decode left tags alone", tag_vec, mdl);

    // R8: forwarding of a same-cycle float load into decode
    begin
      int fr = 0;
      int ir = 0;
      for (int r = 1; r < N; r++) if (mdl[r]) fr = r;
      for (int r = 1; r < N; r++) if (!mdl[r]) ir = r;
      @(negedge clk);
      dec_valid = 1'b1; dec_cls = 3'd1; dec_rs1 = ir[4:0]; dec_rs2 = fr[4:0];
      wb_kind = 3'd3; wb_rd = ir[4:0];
      #1;
      chk("R8 forwarded float load", {unit_sel, res_tag, tag_exc}, 4'b1010);
      @(posedge clk);
      mdl = wb_apply(mdl, 3, ir, 1'b0);
      @(negedge clk);
      idle_inputs();
      dec_valid = 1'b1; dec_cls = 3'd1; dec_rs1 = ir[4:0]; dec_rs2 = fr[4:0];
      wb_kind = 3'd2; wb_rd = fr[4:0];
      #1;
      chk("R8 forwarded int load", {unit_sel, res_tag, tag_exc}, 4'b0001);
      @(posedge clk);
      mdl = wb_apply(mdl, 2, fr, 1'b0);
      @(negedge clk);
      idle_inputs();
      chk("R8 tags after forwarding", tag_vec, mdl);
    end

    // R10 + R9: restore beats load on reg 4, load on reg 1 survives, save same cycle
    @(negedge clk);
    idle_inputs();
    rest_en = 1'b1; rest_mask = 32'h0000_F0F0; rest_tags = 32'hA5A5_A5A5;
    wb_kind = 3'd3; wb_rd = 5'd4;
    save_en = 1'b1; save_mask = 32'h0FF0_00FF;
    dec_valid = 1'b1; dec_cls = 3'd2; dec_rs1 = 5'd4;
    #1;
    chk("R8 R10 restore forwarded to decode", {unit_sel, res_tag, tag_exc}, 4'b0100);
    @(posedge clk);
    mdl = wb_apply(mdl, 3, 4, 1'b0);
    mdl = (mdl & ~32'h0000_F0F0) | (32'hA5A5_A5A5 & 32'h0000_F0F0);
    img = mdl & 32'h0FF0_00FF;
    @(negedge clk);
    idle_inputs();
    chk("R10 restore wins over load", tag_vec[4], 1'b0);
    chk("R10 restore tags", tag_vec, mdl);
    chk("R9 save image", save_img, img);
    @(negedge clk);
    wb_kind = 3'd1; wb_rd = 5'd1; wb_tag = 1'b1;
    rest_en = 1'b1; rest_mask = 32'h0000_0F00; rest_tags = 32'h0000_0000;
    @(posedge clk);
    mdl = wb_apply(mdl, 1, 1, 1'b1);
    mdl = mdl & ~32'h0000_0F00;
    @(negedge clk);
    idle_inputs();
    chk("R10 unmasked write kept", tag_vec, mdl);
    chk("R9 image held without save", save_img, img);
    do_wb(2, 1, 1'b0);
    @(negedge clk);
    save_en = 1'b1; save_mask = 32'hFFFF_FFFF;
    @(posedge clk);
    img = mdl;
    @(negedge clk);
    idle_inputs();
    chk("R9 full save", save_img, img);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule